// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

The controller gathers eight interrupt request lines into a single interrupt output for a host processor. Each line is captured either on its rising edge or as a level, depending on a per-line mode bit. Captured requests are held in a pending register, and a mask register can block each level on its own. A fixed-priority resolver picks the most urgent unmasked pending level. It raises the output only when that level outranks every level already being serviced.

The host acknowledges with a one-cycle active-low strobe. During that cycle the controller drives a vector byte on its read data bus: a programmable 5-bit base in the upper bits and the 3-bit level number in the lower bits. At the clock edge ending the acknowledge, the winning level moves from pending to in-service. Software later writes an end-of-service command, which releases the most urgent in-service level. All registers are reached over an 8-bit port with active-low select, read and write strobes. A write takes effect at every clock edge where select and write are both low.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending and in-service registers read 0x00, the mask reads 0xFF, the mode register reads 0x00 (all lines edge-captured), the base reads 0x00 and `int_o` is low.
- R2: A line in edge mode (mode bit 0) sets its pending bit at the first clock edge after a low-to-high change. Holding the line high does not set the bit again after it has been cleared. The line must go low and then high again.
- R3: A line in level mode (mode bit 1) makes its pending bit follow the input one clock later. A line still held high after acknowledge therefore requests again.
- R4: A set mask bit keeps its level out of arbitration, but the pending bit is still recorded. Clearing the mask bit lets a held request raise `int_o`.
- R5: Among unmasked pending levels, level 0 has the highest priority and level 7 the lowest.
- R6: `int_o` is high only when the winning level has a lower number than every set in-service bit. A request of equal or lower priority stays silent until that level is released.
- R7: While `inta_ni` is low, `rdata_o` carries {base[4:0], level[2:0]}. If `int_o` was high, the clock edge clears that level's pending bit and sets its in-service bit.
- R8: An acknowledge while `int_o` is low returns {base, 3'b111} and changes neither the pending nor the in-service register.
- R9: A write to address 0 with data bit 5 set clears the lowest-numbered set in-service bit. A write to address 0 with bit 5 clear changes nothing.
- R10: Address map: 0 pending (read) / command (write), 1 mask, 2 in-service (read only), 3 mode, 4 base in bits 7:3. Reads return data only while `cs_ni` and `rd_ni` are low, and 0x00 otherwise. Writes are ignored while `cs_ni` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request lines, line 0 most urgent |
| cs_ni | input | 1 | Register port select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data or acknowledge vector |
| inta_ni | input | 1 | Acknowledge strobe, active low, one cycle |
| int_o | output | 1 | Interrupt request toward the host |

## Verification
A wrong pending or in-service bit shows up on `int_o` in the same cycle, because the output is decoded straight from the registers. It also corrupts the low three bits of the next acknowledge vector. A stale in-service bit holds back lower-priority requests until the end-of-service command that should have freed them. The bench compares `int_o` every cycle and every read or vector byte against a cycle-level model, so a divergence is reported within one clock of the state going wrong.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 3;
  localparam int unsigned EOI_BIT = 5;

  typedef enum logic [AW-1:0] {
    A_PEND = 3'd0,
    A_MASK = 3'd1,
    A_SERV = 3'd2,
    A_MODE = 3'd3,
    A_BASE = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/pic_req_capture.sv
module pic_req_capture #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] irq_q;
  logic [N-1:0] irr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    logic rise;
    assign rise = irq_i[g] & ~irq_q[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          irr_q[g] <= 1'b0;
      else if (level_i[g])  irr_q[g] <= irq_i[g] & ~clr_i[g];
      else                  irr_q[g] <= (irr_q[g] | rise) & ~clr_i[g];
    end

    // R2: an edge-mode bit cannot appear without a fresh rising edge
    a_r2_edge_needs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!level_i[g] && !irr_q[g] && !(irq_i[g] && !irq_q[g])) |=> !irr_q[g]);
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  irr_i,
  input  logic [N-1:0]  imr_i,
  input  logic [N-1:0]  isr_i,
  output logic          req_o,
  output logic [LW-1:0] win_idx_o,
  output logic [N-1:0]  win_oh_o
);
  logic [N-1:0]  pend;
  logic          win_ok;
  logic          busy;
  logic [LW-1:0] top_idx;

  always_comb begin
    pend      = irr_i & ~imr_i;
    win_ok    = 1'b0;
    win_idx_o = '0;
    busy      = 1'b0;
    top_idx   = '0;
    // scan downward so the lowest index is taken last
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        win_ok    = 1'b1;
        win_idx_o = LW'(i);
      end
      if (isr_i[i]) begin
        busy    = 1'b1;
        top_idx = LW'(i);
      end
    end
    req_o    = win_ok && (!busy || (win_idx_o < top_idx));
    win_oh_o = '0;
    if (win_ok) win_oh_o[win_idx_o] = 1'b1;
  end
endmodule

// File: rtl/pic_inservice.sv
module pic_inservice #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ack_i,
  input  logic         spur_i,
  input  logic [N-1:0] set_oh_i,
  input  logic         eoi_i,
  output logic [N-1:0] isr_o
);
  logic [N-1:0] isr_q;
  logic [N-1:0] low_bit;
  logic [N-1:0] isr_d;

  always_comb begin
    low_bit = isr_q & (~isr_q + 1'b1);
    isr_d   = isr_q;
    if (eoi_i) isr_d = isr_d & ~low_bit;
    if (ack_i) isr_d = isr_d | set_oh_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_d;
  end

  assign isr_o = isr_q;

  // R7: an accepted acknowledge leaves its level in service
  a_r7_ack_sets_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> ((isr_q & $past(set_oh_i)) == $past(set_oh_i)));

  // R8: a spurious acknowledge with no command leaves the register alone
  a_r8_spurious_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spur_i && !eoi_i) |=> $stable(isr_q));

  // R9: end-of-service alone releases at most one level
  a_r9_eoi_drops_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && (isr_q != '0)) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          inta_ni,
  input  logic [N-1:0]  irr_i,
  input  logic [N-1:0]  isr_i,
  input  logic          req_i,
  input  logic [LW-1:0] win_idx_i,
  output logic [N-1:0]  imr_o,
  output logic [N-1:0]  level_o,
  output logic          eoi_o,
  output logic          ack_o,
  output logic          spur_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned BW = DW - LW;

  logic [N-1:0]  imr_q;
  logic [N-1:0]  mode_q;
  logic [BW-1:0] base_q;
  logic          wr_en;
  logic          rd_en;
  logic [LW-1:0] vec_lvl;
  logic [DW-1:0] rd_mux;
  reg_addr_e     sel;

  assign sel   = reg_addr_e'(addr_i);
  assign wr_en = !cs_ni && !wr_ni;
  assign rd_en = !cs_ni && !rd_ni;
  assign eoi_o = wr_en && (sel == A_PEND) && wdata_i[EOI_BIT];
  assign ack_o  = !inta_ni && req_i;
  assign spur_o = !inta_ni && !req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_q  <= '1;
      mode_q <= '0;
      base_q <= '0;
    end else if (wr_en) begin
      case (sel)
        A_MASK:  imr_q  <= wdata_i[N-1:0];
        A_MODE:  mode_q <= wdata_i[N-1:0];
        A_BASE:  base_q <= wdata_i[DW-1:LW];
        default: ;
      endcase
    end
  end

  assign vec_lvl = req_i ? win_idx_i : '1;

  always_comb begin
    rd_mux = '0;
    case (sel)
      A_PEND:  rd_mux[N-1:0] = irr_i;
      A_MASK:  rd_mux[N-1:0] = imr_q;
      A_SERV:  rd_mux[N-1:0] = isr_i;
      A_MODE:  rd_mux[N-1:0] = mode_q;
      A_BASE:  rd_mux[DW-1:LW] = base_q;
      default: rd_mux = '0;
    endcase
    if (!inta_ni)   rdata_o = {base_q, vec_lvl};
    else if (rd_en) rdata_o = rd_mux;
    else            rdata_o = '0;
  end

  assign imr_o   = imr_q;
  assign level_o = mode_q;

  // R10: port is silent when not selected and not acknowledging
  a_r10_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && inta_ni) |-> (rdata_o == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned N_IRQ = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             inta_ni,
  output logic             int_o
);
  localparam int unsigned LW = $clog2(N_IRQ);

  logic [N_IRQ-1:0] irr, isr, imr, level, win_oh, clr;
  logic [LW-1:0]    win_idx;
  logic             req, ack, spur, eoi;

  assign clr = ack ? win_oh : '0;

  pic_req_capture #(.N(N_IRQ)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i),
    .level_i(level), .clr_i(clr), .irr_o(irr)
  );

  pic_resolver #(.N(N_IRQ), .LW(LW)) u_res (
    .irr_i(irr), .imr_i(imr), .isr_i(isr),
    .req_o(req), .win_idx_o(win_idx), .win_oh_o(win_oh)
  );

  pic_inservice #(.N(N_IRQ)) u_srv (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack), .spur_i(spur),
    .set_oh_i(win_oh), .eoi_i(eoi), .isr_o(isr)
  );

  pic_regs #(.N(N_IRQ), .LW(LW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni),
    .wr_ni(wr_ni), .addr_i(addr_i), .wdata_i(wdata_i), .inta_ni(inta_ni),
    .irr_i(irr), .isr_i(isr), .req_i(req), .win_idx_i(win_idx),
    .imr_o(imr), .level_o(level), .eoi_o(eoi), .ack_o(ack),
    .spur_o(spur), .rdata_o(rdata_o)
  );

  assign int_o = req;

  // R4: output only with an unmasked pending level behind it
  a_r4_masked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr & ~imr) != '0));

  // R7: an accepted level leaves the pending register
  a_r7_ack_clears_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !(level & win_oh)) |=> ((irr & $past(win_oh)) == '0));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, inta_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       int_o;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  // bench model
  logic [7:0] m_irr = '0, m_isr = '0, m_imr = 8'hFF, m_mode = '0, m_irqq = '0;
  logic [4:0] m_base = '0;

  always #2 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .cs_ni(cs_n), .rd_ni(rd_n),
    .wr_ni(wr_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .inta_ni(inta_n), .int_o(int_o)
  );

  function automatic int lowest(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic exp_int();
    int w = lowest(m_irr & ~m_imr);
    int t = lowest(m_isr);
    return (w < 8) && (w < t);
  endfunction

  function automatic logic [7:0] exp_rdata();
    int w = lowest(m_irr & ~m_imr);
    if (!inta_n) return {m_base, exp_int() ? 3'(w) : 3'b111};
    if (!cs_n && !rd_n) begin
      case (addr)
        3'd0: return m_irr;
        3'd1: return m_imr;
        3'd2: return m_isr;
        3'd3: return m_mode;
        3'd4: return {m_base, 3'b000};
        default: return 8'h00;
      endcase
    end
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic       ackv = !inta_n && exp_int();
    int         w = lowest(m_irr & ~m_imr);
    logic [7:0] n_irr;
    logic [7:0] n_isr = m_isr;
    for (int i = 0; i < 8; i++) begin
      logic c = ackv && (i == w);
      if (m_mode[i]) n_irr[i] = irq[i] && !c;
      else           n_irr[i] = (m_irr[i] || (irq[i] && !m_irqq[i])) && !c;
    end
    if (!cs_n && !wr_n && addr == 3'd0 && wdata[5]) begin
      int t = lowest(m_isr);
      if (t < 8) n_isr[t] = 1'b0;
    end
    if (ackv) n_isr[w] = 1'b1;
    if (!cs_n && !wr_n) begin
      if (addr == 3'd1) m_imr  = wdata;
      if (addr == 3'd3) m_mode = wdata;
      if (addr == 3'd4) m_base = wdata[7:3];
    end
    m_irr  = n_irr;
    m_isr  = n_isr;
    m_irqq = irq;
  endtask

  // inputs already set at negedge; check, advance, return at next negedge
  task automatic cycle();
    #1;
    chk({cur_tag, "/R6 int"}, {7'd0, int_o}, {7'd0, exp_int()});
    if (!inta_n)            chk({cur_tag, "/R7 vec"}, rdata, exp_rdata());
    else if (!cs_n && !rd_n) chk({cur_tag, "/R10 rd"}, rdata, exp_rdata());
    else if (cs_n)          chk({cur_tag, "/R10 idle"}, rdata, 8'h00);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic bus_idle();
    cs_n = 1; rd_n = 1; wr_n = 1; inta_n = 1;
  endtask

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    cs_n = 0; wr_n = 0; addr = a; wdata = d;
    cycle();
    bus_idle();
  endtask

  task automatic rd_reg(logic [2:0] a);
    cs_n = 0; rd_n = 0; addr = a;
    cycle();
    bus_idle();
  endtask

  task automatic do_ack();
    inta_n = 0;
    cycle();
    inta_n = 1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic rd_all();
    for (int a = 0; a < 5; a++) rd_reg(3'(a));
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed = $urandom(32'd4711);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    cur_tag = "R1"; rd_all();

    cur_tag = "R4";
    irq = 8'h08; idle(2);
    rd_reg(3'd0);                 // pending recorded while masked
    wr_reg(3'd1, 8'h00);
    idle(1);

    cur_tag = "R2";
    wr_reg(3'd4, 8'hA8);
    do_ack();                     // level 3 in service
    idle(3); rd_all();            // held high: no re-request
    irq = 8'h00; idle(1); irq = 8'h08; idle(2);
    rd_reg(3'd0);
    cur_tag = "R9";
    wr_reg(3'd0, 8'h00); rd_reg(3'd2);
    wr_reg(3'd0, 8'h20); rd_reg(3'd2);
    do_ack(); wr_reg(3'd0, 8'h20);
    irq = 8'h00; idle(2);

    cur_tag = "R3";
    wr_reg(3'd3, 8'h20);
    irq = 8'h20; idle(2);
    do_ack(); idle(2); rd_all();
    wr_reg(3'd0, 8'h20); idle(1);
    irq = 8'h00; idle(2); rd_reg(3'd0);
    wr_reg(3'd3, 8'h00);

    cur_tag = "R5";
    irq = 8'h44; idle(2);
    do_ack(); rd_reg(3'd2);

    cur_tag = "R6";
    irq = 8'h00; idle(1);
    irq = 8'h02; idle(2);        // level 1 beats level 2 in service
    do_ack(); idle(1);            // level 6 still pending, blocked
    wr_reg(3'd0, 8'h20); wr_reg(3'd0, 8'h20);
    idle(1); do_ack(); wr_reg(3'd0, 8'h20);

    cur_tag = "R8";
    irq = 8'h00; idle(2);
    do_ack(); rd_all();

    cur_tag = "R10";
    cs_n = 1; wr_n = 0; addr = 3'd1; wdata = 8'h5A; cycle(); bus_idle();
    rd_reg(3'd1); rd_reg(3'd7);

    cur_tag = "R7";
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom % 100;
      if ($urandom % 4 == 0) irq = irq ^ (8'd1 << ($urandom % 8));
      if (r < 12)       inta_n = 0;
      else if (r < 22)  begin cs_n = 0; wr_n = 0; addr = 3'd0; wdata = 8'h20; end
      else if (r < 25)  begin cs_n = 0; wr_n = 0; addr = 3'd1; wdata = 8'($urandom); end
      else if (r < 27)  begin cs_n = 0; wr_n = 0; addr = 3'd3; wdata = 8'($urandom); end
      else if (r < 28)  begin cs_n = 0; wr_n = 0; addr = 3'd4; wdata = 8'($urandom); end
      else if (r < 45)  begin cs_n = 0; rd_n = 0; addr = 3'($urandom % 5); end
      cycle();
      bus_idle();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule